// File: doc/BRIEF.md
# Dual Auto-Stepping Memory Access Port

This block lets an 8-bit host reach a large banked local memory one byte at a time through a small register window. It holds two independent access ports. Each port keeps a 16-bit pointer, a 3-bit bank number and a signed 8-bit increment. Every data transfer through a port touches the byte at that port's bank and pointer. After the transfer, the pointer moves by the sign-extended increment. The pointer wraps within its 64 KiB bank and never carries into the bank number.

Host writes to a port's data register are queued as memory writes. A write is placed on the memory bus on the next clock cycle. Reads of a port's data register are answered at once from a per-port prefetch byte. The block refills that byte in the background whenever the port's pointer or bank changes, and after any memory write. This keeps the prefetched copy consistent across both ports.

Both ports share one synchronous memory. The memory has a one-cycle read latency. A fixed-priority arbiter grants the bus to one request per cycle.

Top module: `autostep_port_pair`

## Requirements
- R1: During and after reset the block never asserts memWe, and every pointer, increment and bank register of both ports reads back as zero.
- R2: hostAddr[3] picks the port (0 or 1). hostAddr[2:0] picks the register: 0 pointer low byte, 1 pointer high byte, 2 data, 3 signed increment, 4 bank. Bank reads back in bits 2:0 with zeros above. Selects 5 to 7 read as zero, and writes to them change nothing. Register reads are combinational within the same cycle.
- R3: A host write to a data register drives memEn=1 and memWe=1 on the next cycle, with that port's bank and pre-transfer pointer on memBank/memAddr and the written byte on memWrData.
- R4: After every data transfer (read or write), the port's pointer becomes pointer plus the sign-extended increment, modulo 65536. The bank does not change.
- R5: With an increment of zero, the pointer stays put, so successive transfers reach the same byte.
- R6: A data read returns the byte stored at the port's current bank and pointer, provided at least six idle cycles have passed since that port's last pointer or bank change or since any data write.
- R7: An operation on one port leaves the other port's pointer, increment and bank unchanged.
- R8: A byte written through one port is returned by a data read through the other port aimed at the same location, after the settle time of R6.
- R9: Pending writes win the bus over prefetch reads. Between two requests of the same kind, port 0 wins and port 1 is served on the following cycle. After a lone data write to port 0, the bus shows the write, then the port 0 refill, then the port 1 refill, on three consecutive cycles.
- R10: When hostWrEn and hostRdEn are both high, only the write takes effect, so a data access advances the pointer once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (advances pointer on data reads) |
| hostAddr | input | 4 | Port select (bit 3) and register select (bits 2:0) |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Selected register value, combinational |
| memEn | output | 1 | Memory access request this cycle |
| memWe | output | 1 | Memory write when high, read when low |
| memBank | output | 3 | Memory bank number |
| memAddr | output | 16 | Byte offset within the bank |
| memWrData | output | 8 | Memory write byte |
| memRdData | input | 8 | Memory read byte, valid the cycle after a read request |

## Verification
Host inputs are driven at the falling edge. Register read-back is taken one time unit after the strobe, in the same cycle, because that path has no register. The memory write caused by a data write is sampled at the next falling edge, one cycle later. In the directed arbitration case, the two refill reads are sampled on the two falling edges after that. Every pointer change or data write is followed by six idle cycles before the next operation. This covers the worst chain of write, port 0 refill and port 1 refill plus the memory's one-cycle latency, so every data read compares against a settled prefetch byte.

// File: rtl/autostep_pkg.sv
package autostep_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 2 * DATA_W;
  parameter int BANK_W = 3;
  parameter int SEL_W  = 3;
  localparam int PORTS = 2;  // fixed-priority arbiter is written for two requesters

  typedef enum logic [SEL_W-1:0] {
    SEL_PTR_LO = 3'd0,
    SEL_PTR_HI = 3'd1,
    SEL_DATA   = 3'd2,
    SEL_STEP   = 3'd3,
    SEL_BANK   = 3'd4
  } regSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic [PORTS-1:0] ldLo;
    logic [PORTS-1:0] ldHi;
    logic [PORTS-1:0] ldStep;
    logic [PORTS-1:0] ldBank;
    logic [PORTS-1:0] advance;
    logic [PORTS-1:0] latchWr;
    logic [PORTS-1:0] capture;
    logic             memEn;
    logic             memWe;
    logic             grantPort;
  } strobesT;
endpackage

// File: rtl/autostep_ctrl.sv
module autostep_ctrl
  import autostep_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           hostWrEn,
  input  logic           hostRdEn,
  input  logic [SEL_W:0] hostAddr,
  output strobesT        strb
);
  logic [PORTS-1:0] wrPend, fetchPend, ptrChange, grantWr, grantRd;
  logic             rdBusy, rdPort, rdEff;
  logic [SEL_W-1:0] sel;

  assign rdEff = hostRdEn & ~hostWrEn;
  assign sel   = hostAddr[SEL_W-1:0];

  always_comb begin
    strb      = '0;
    grantWr   = '0;
    grantRd   = '0;
    ptrChange = '0;
    for (int p = 0; p < PORTS; p++) begin
      logic mine;
      mine = (hostAddr[SEL_W] == p[0]);
      strb.ldLo[p]    = hostWrEn & mine & (sel == SEL_PTR_LO);
      strb.ldHi[p]    = hostWrEn & mine & (sel == SEL_PTR_HI);
      strb.ldStep[p]  = hostWrEn & mine & (sel == SEL_STEP);
      strb.ldBank[p]  = hostWrEn & mine & (sel == SEL_BANK);
      strb.latchWr[p] = hostWrEn & mine & (sel == SEL_DATA);
      strb.advance[p] = (hostWrEn | rdEff) & mine & (sel == SEL_DATA);
      strb.capture[p] = rdBusy & (rdPort == p[0]);
      ptrChange[p]    = strb.ldLo[p] | strb.ldHi[p] | strb.ldBank[p] | strb.advance[p];
    end
    // writes before refills, port 0 before port 1
    if (wrPend[0])         grantWr[0] = 1'b1;
    else if (wrPend[1])    grantWr[1] = 1'b1;
    else if (fetchPend[0]) grantRd[0] = 1'b1;
    else if (fetchPend[1]) grantRd[1] = 1'b1;
    strb.memEn     = |(grantWr | grantRd);
    strb.memWe     = |grantWr;
    strb.grantPort = grantWr[1] | grantRd[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPend    <= '0;
      fetchPend <= '1;  // load both prefetch bytes after reset
      rdBusy    <= 1'b0;
      rdPort    <= 1'b0;
    end else begin
      for (int p = 0; p < PORTS; p++) begin
        wrPend[p]    <= strb.latchWr[p] | (wrPend[p] & ~grantWr[p]);
        fetchPend[p] <= ptrChange[p] | strb.memWe | (fetchPend[p] & ~grantRd[p]);
      end
      rdBusy <= strb.memEn & ~strb.memWe;
      rdPort <= strb.grantPort;
    end
  end
endmodule

// File: rtl/autostep_dp.sv
module autostep_dp
  import autostep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobesT           strb,
  input  logic [SEL_W:0]    hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic [BANK_W-1:0] memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ptr    [PORTS];
  logic [ADDR_W-1:0] wrAddr [PORTS];
  logic [DATA_W-1:0] step   [PORTS];
  logic [DATA_W-1:0] rdBuf  [PORTS];
  logic [DATA_W-1:0] wrData [PORTS];
  logic [BANK_W-1:0] bank   [PORTS];
  logic [BANK_W-1:0] wrBank [PORTS];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [ADDR_W-1:0] stepExt;
    assign stepExt = {{EXT_W{step[p][DATA_W-1]}}, step[p]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptr[p]    <= '0;
        step[p]   <= '0;
        bank[p]   <= '0;
        rdBuf[p]  <= '0;
        wrAddr[p] <= '0;
        wrBank[p] <= '0;
        wrData[p] <= '0;
      end else begin
        if (strb.ldLo[p])          ptr[p][DATA_W-1:0]      <= hostWrData;
        else if (strb.ldHi[p])     ptr[p][ADDR_W-1:DATA_W] <= hostWrData;
        else if (strb.advance[p])  ptr[p]                  <= ptr[p] + stepExt;
        if (strb.ldStep[p])        step[p] <= hostWrData;
        if (strb.ldBank[p])        bank[p] <= hostWrData[BANK_W-1:0];
        if (strb.latchWr[p]) begin
          wrAddr[p] <= ptr[p];
          wrBank[p] <= bank[p];
          wrData[p] <= hostWrData;
        end
        if (strb.capture[p])       rdBuf[p] <= memRdData;
      end
    end
  end

  always_comb begin
    memAddr   = strb.memWe ? wrAddr[strb.grantPort] : ptr[strb.grantPort];
    memBank   = strb.memWe ? wrBank[strb.grantPort] : bank[strb.grantPort];
    memWrData = wrData[strb.grantPort];
  end

  always_comb begin
    logic hp;
    hp = hostAddr[SEL_W];
    case (hostAddr[SEL_W-1:0])
      SEL_PTR_LO: hostRdData = ptr[hp][DATA_W-1:0];
      SEL_PTR_HI: hostRdData = ptr[hp][ADDR_W-1:DATA_W];
      SEL_DATA:   hostRdData = rdBuf[hp];
      SEL_STEP:   hostRdData = step[hp];
      SEL_BANK:   hostRdData = {{(DATA_W-BANK_W){1'b0}}, bank[hp]};
      default:    hostRdData = '0;
    endcase
  end
endmodule

// File: rtl/autostep_port_pair.sv
module autostep_port_pair
  import autostep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [SEL_W:0]    hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              memEn,
  output logic              memWe,
  output logic [BANK_W-1:0] memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);
  strobesT strb;

  autostep_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .hostAddr (hostAddr),
    .strb     (strb)
  );

  autostep_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .memBank    (memBank),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memRdData  (memRdData)
  );

  assign memEn = strb.memEn;
  assign memWe = strb.memWe;
endmodule

// File: rtl/autostep_checker.sv
module autostep_checker
  import autostep_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic [SEL_W:0]    hostAddr,
  input logic [DATA_W-1:0] hostWrData,
  input logic [DATA_W-1:0] hostRdData,
  input logic              memEn,
  input logic              memWe,
  input logic [DATA_W-1:0] memWrData
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_DATA_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    armed && hostWrEn && hostAddr[SEL_W-1:0] == SEL_DATA
    |=> memEn && memWe && memWrData == $past(hostWrData)); // R3

  AST_WRITE_ONLY_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    armed && memWe |-> $past(hostWrEn) && $past(hostAddr[SEL_W-1:0]) == SEL_DATA); // R9

  AST_STEP_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    armed && hostWrEn && hostAddr[SEL_W-1:0] == SEL_STEP
    |=> hostWrEn || hostAddr != $past(hostAddr) || hostRdData == $past(hostWrData)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    armed && hostAddr[SEL_W-1:0] > 3'd4 |-> hostRdData == '0); // R2

  AST_PTR_HOLDS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    armed && !hostWrEn && !hostRdEn && hostAddr[SEL_W-1:0] == SEL_PTR_LO
    |=> hostAddr != $past(hostAddr) || $stable(hostRdData)); // R4

  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk)
    !rstN |-> !memWe); // R1
endmodule

bind autostep_port_pair autostep_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostRdEn   (hostRdEn),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .memEn      (memEn),
  .memWe      (memWe),
  .memWrData  (memWrData)
);

// File: tb/autostep_port_pair_bench.sv
module autostep_port_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic        memEn, memWe;
  logic [2:0]  memBank;
  logic [15:0] memAddr;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData = '0;

  int checks = 0, failures = 0;
  bit done = 0, reported = 0;

  logic [7:0]  memModel [int];
  logic [7:0]  refMem   [int];
  logic [15:0] refPtr  [2];
  logic [7:0]  refStep [2];
  logic [2:0]  refBank [2];

  logic        busEn, busWe;
  logic [2:0]  busBank;
  logic [15:0] busAddr;
  logic [7:0]  busData;

  always #(CLK_PERIOD/2) clk = ~clk;

  autostep_port_pair u_autostep_port_pair (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .memEn(memEn), .memWe(memWe), .memBank(memBank), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  // synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) memModel[int'({memBank, memAddr})] = memWrData;
      else memRdData <= memModel.exists(int'({memBank, memAddr})) ?
                        memModel[int'({memBank, memAddr})] : 8'h00;
    end
  end

  function automatic int keyOf(logic [2:0] b, logic [15:0] a);
    return int'({b, a});
  endfunction

  function automatic logic [15:0] stepped(logic [15:0] a, logic [7:0] s);
    return a + {{8{s[7]}}, s};
  endfunction

  function automatic logic [7:0] refRead(int k);
    return refMem.exists(k) ? refMem[k] : 8'h00;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // raw host write; captures the memory bus one cycle later
  task automatic hostWr(logic [3:0] a, logic [7:0] d);
    hostWrEn = 1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    busEn = memEn; busWe = memWe; busBank = memBank; busAddr = memAddr; busData = memWrData;
    hostWrEn = 0;
  endtask

  task automatic hostRd(logic [3:0] a, output logic [7:0] d);
    hostRdEn = 1; hostAddr = a;
    #1 d = hostRdData;
    @(negedge clk);
    hostRdEn = 0;
  endtask

  task automatic applyModel(int p, int sel, logic [7:0] v);
    case (sel)
      0: refPtr[p][7:0]  = v;
      1: refPtr[p][15:8] = v;
      2: begin refMem[keyOf(refBank[p], refPtr[p])] = v; refPtr[p] = stepped(refPtr[p], refStep[p]); end
      3: refStep[p] = v;
      4: refBank[p] = v[2:0];
      default: ;
    endcase
  endtask

  task automatic opWrite(int p, int sel, logic [7:0] v);
    hostWr({p[0], sel[2:0]}, v);
    applyModel(p, sel, v);
    idle(SETTLE);
  endtask

  task automatic opRead(int p, int sel, string req);
    logic [7:0] got, exp;
    case (sel)
      0: exp = refPtr[p][7:0];
      1: exp = refPtr[p][15:8];
      2: exp = refRead(keyOf(refBank[p], refPtr[p]));
      3: exp = refStep[p];
      4: exp = {5'b0, refBank[p]};
      default: exp = 8'h00;
    endcase
    hostRd({p[0], sel[2:0]}, got);
    check(req, got, exp);
    if (sel == 2) begin
      refPtr[p] = stepped(refPtr[p], refStep[p]);
      idle(SETTLE);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

  initial begin
    logic [7:0] got;
    void'($urandom(32'h1A2B3C4D));
    for (int p = 0; p < 2; p++) begin refPtr[p] = '0; refStep[p] = '0; refBank[p] = '0; end

    // R1: reset
    repeat (4) begin
      @(negedge clk);
      check("R1 memWe in reset", memWe, 0);
    end
    rstN = 1;
    idle(SETTLE);
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 5; s++)
        if (s != 2) opRead(p, s, "R1 reset value");

    // R2: unmapped selects
    hostWr(4'h5, 8'h77);
    idle(SETTLE);
    for (int s = 5; s < 8; s++) opRead(0, s, "R2 unmapped reads zero");
    opRead(0, 0, "R2 unmapped write ignored");
    opWrite(1, 4, 8'hFF);
    opRead(1, 4, "R2 bank width");

    // R3 + R9: write then two refills in priority order
    opWrite(1, 0, 8'h34); opWrite(1, 1, 8'h12); opWrite(1, 4, 8'h02);
    opWrite(0, 0, 8'hFE); opWrite(0, 1, 8'hFF); opWrite(0, 3, 8'h01); opWrite(0, 4, 8'h05);
    hostWr(4'h2, 8'hA5);
    applyModel(0, 2, 8'hA5);
    check("R3 write enable", {busEn, busWe}, 2'b11);
    check("R3 write addr", busAddr, 16'hFFFE);
    check("R3 write bank", busBank, 3'd5);
    check("R3 write data", busData, 8'hA5);
    @(negedge clk);
    check("R9 port0 refill first", {memEn, memWe, memBank, memAddr}, {2'b10, 3'd5, 16'hFFFF});
    @(negedge clk);
    check("R9 port1 refill next", {memEn, memWe, memBank, memAddr}, {2'b10, 3'd2, 16'h1234});
    idle(SETTLE);

    // R4: wrap and negative increment
    opWrite(0, 2, 8'h5A);
    opRead(0, 0, "R4 wrap low");
    opRead(0, 1, "R4 wrap high");
    opRead(0, 4, "R4 bank unchanged");
    opWrite(0, 0, 8'h10); opWrite(0, 1, 8'h00); opWrite(0, 3, 8'h80);
    opWrite(0, 2, 8'h3E);
    opRead(0, 0, "R4 minus 128 low");
    opRead(0, 1, "R4 minus 128 high");

    // R5: zero increment
    opWrite(0, 3, 8'h00); opWrite(0, 0, 8'h40);
    opWrite(0, 2, 8'h11); opWrite(0, 2, 8'h22);
    opRead(0, 2, "R5 same location");
    opRead(0, 0, "R5 pointer unchanged");

    // R8: cross-port visibility
    opWrite(1, 4, 8'h05); opWrite(1, 0, 8'h40); opWrite(1, 1, 8'h00); opWrite(1, 3, 8'h00);
    opWrite(0, 2, 8'h3C);
    opRead(1, 2, "R8 other port sees write");

    // R10: both strobes on data register
    opWrite(0, 3, 8'h01); opWrite(0, 4, 8'h03); opWrite(0, 0, 8'h00); opWrite(0, 1, 8'h02);
    hostRdEn = 1;
    hostWr(4'h2, 8'h99);
    hostRdEn = 0;
    applyModel(0, 2, 8'h99);
    check("R10 write wins", {busWe, busData}, {1'b1, 8'h99});
    idle(SETTLE);
    opRead(0, 0, "R10 single advance");

    // random mix over both ports: R6, R7, R4
    for (int i = 0; i < 400; i++) begin
      int p, op;
      logic [7:0] v;
      p  = $urandom_range(0, 1);
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 5))
        0: v = 8'h00; 1: v = 8'h01; 2: v = 8'hFF; 3: v = 8'h7F; 4: v = 8'h80;
        default: v = 8'($urandom);
      endcase
      case (op)
        0: opWrite(p, 0, 8'($urandom));
        1: opWrite(p, 1, v);
        2: opWrite(p, 3, v);
        3: opWrite(p, 4, 8'($urandom_range(0, 2)));
        4, 5: opWrite(p, 2, 8'($urandom));
        6, 7: opRead(p, 2, "R6 prefetched data");
        8: opRead(p, $urandom_range(0, 1), "R7 R4 pointer");
        default: opRead(p, $urandom_range(3, 4), "R7 step bank");
      endcase
    end

    done = 1;
    report();
  end
endmodule